// File: doc/BRIEF.md
# Match-Compare Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. A 32-bit up-counter advances on a fixed-rate tick enable whenever software has turned counting on. When the counter equals a programmed match value on a counting cycle, the block produces a single-cycle match event. That event can set a sticky interrupt flag, stop and zero the counter, change an external match pin, and start a reset pulse on an internal and/or an external reset output. Each of these actions has its own enable.

Software starts the watchdog in a fixed order. It clears the counter and polls the counter until it reads zero. It then programs the actions, the pulse length and the match value (timeout in seconds times the tick rate), and finally enables counting. A keep-alive repeats this sequence. A sticky reset-cause flag records that a match-driven reset pulse was issued. The flag survives the ordinary synchronous reset, so boot code can report a watchdog-caused restart. Only the power-on reset clears it.

Registers sit at byte offsets 0x00 (interrupt flag), 0x04 (control), 0x08 (counter), 0x0C (action enables), 0x10 (match value), 0x14 (pin mode), 0x18 (pulse length) and 0x1C (reset cause).

Top module: `wdog_match_timer`

## Requirements
- R1: After power-on reset, every register reads zero, and irq, ext_match, int_rst and ext_rst are low.
- R2: With control bit 0 set, the counter at 0x08 rises by one on each clock edge where tick is high. It holds when tick is low or bit 0 is clear.
- R3: With control bit 2 set, the counter holds while dbg_halt is high. With bit 2 clear, dbg_halt has no effect.
- R4: Writing control with bit 1 set zeroes the counter no later than the second clock edge after the write. If bit 0 was written as 0, the counter then stays at zero and control reads back 0.
- R5: A match (counter equal to the match value at 0x10 on a counting edge) sets bit 0 of 0x00. The irq pin equals that flag ANDed with action bit 0 of 0x0C. Writing 1 to bit 0 of 0x00 clears the flag, and writing 0 leaves it unchanged.
- R6: With action bit 2 of 0x0C set, a match zeroes the counter and clears control bit 0, so counting stops.
- R7: With action bit 2 clear, the counter steps past the match value as usual.
- R8: With action bit 3 (internal) or bit 4 (external) set, a match drives that reset output high for exactly the 16-bit pulse length at 0x18 plus 6 ticks. The other output stays low.
- R9: Action bits 5 and 6 of 0x0C drive int_rst and ext_rst high directly for as long as they are set.
- R10: Bits 5:4 of 0x14 choose the pin action on each match: 0 keeps the pin, 1 drives it low, 2 drives it high, 3 toggles it. Bit 0 of 0x14 reads the pin level, and writing bit 0 loads the pin.
- R11: Bit 0 of 0x1C is set when a match starts a reset pulse. Bus writes do not change it. It stays set through the synchronous reset, and only power-on reset clears it. Forced outputs do not set it.
- R12: A 60-second timeout at 13 MHz (780,000,000) and a pulse length of 0xFFFF are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; keeps the reset-cause flag |
| por | input | 1 | Synchronous active-high power-on reset; clears everything |
| tick | input | 1 | Fixed-rate counter enable |
| dbg_halt | input | 1 | Debugger halt indication |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high, zero otherwise |
| irq | output | 1 | Match interrupt |
| ext_match | output | 1 | External match pin |
| int_rst | output | 1 | Internal reset request |
| ext_rst | output | 1 | External reset request |

## Verification
The hardest case to reach from the ports is the exact length of a match-driven reset pulse. It needs the counter cleared, the actions and match value set up, and then a run of unbroken ticks across the match. The stimulus therefore holds tick high continuously from the enabling write onward, and counts the cycles in which each reset output is high over a window that is longer than the pulse. The surviving reset-cause flag is reached by following that pulse with a synchronous reset and then a power-on reset. The pin modes are stepped through by using a match value of zero, so that one tick after each enabling write produces a match.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned TICK_HZ       = 13_000_000;
    localparam int unsigned MAX_TIMEOUT_S = 60;

    typedef enum logic [1:0] {
        EM_HOLD   = 2'd0,
        EM_LOW    = 2'd1,
        EM_HIGH   = 2'd2,
        EM_TOGGLE = 2'd3
    } em_mode_e;

    typedef enum logic [2:0] {
        RA_IRQ   = 3'd0,
        RA_CTRL  = 3'd1,
        RA_CNT   = 3'd2,
        RA_ACT   = 3'd3,
        RA_MATCH = 3'd4,
        RA_PIN   = 3'd5,
        RA_PLEN  = 3'd6,
        RA_CAUSE = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic force_ext;
        logic force_int;
        logic ext_rst_en;
        logic int_rst_en;
        logic stop_on_match;
        logic irq_en;
    } act_t;

    function automatic logic em_next(em_mode_e m, logic cur);
        case (m)
            EM_LOW:    return 1'b0;
            EM_HIGH:   return 1'b1;
            EM_TOGGLE: return ~cur;
            default:   return cur;
        endcase
    endfunction

    function automatic logic [63:0] timeout_ticks(int unsigned secs);
        return 64'(secs) * 64'(TICK_HZ);
    endfunction

endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_en,
    input  logic             clr_req,
    input  logic             stop_on_match,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] cnt,
    output logic             match_hit
);

    assign match_hit = count_en && (cnt == match_val);

    always_ff @(posedge clk) begin
        if (rst)                            cnt <= '0;
        else if (clr_req)                   cnt <= '0;
        else if (match_hit && stop_on_match) cnt <= '0;
        else if (count_en)                  cnt <= cnt + 1'b1;
    end

    // R4: a pending clear request zeroes the counter at the next edge
    a_r4_clear_done: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> (cnt == '0));

    // R7: without stop, a match does not disturb counting
    a_r7_step_past: assert property (@(posedge clk) disable iff (rst)
        (match_hit && !stop_on_match && !clr_req) |=> (cnt == $past(cnt) + 1'b1));

    // R6: stop-on-match leaves the counter at zero
    a_r6_stop_zero: assert property (@(posedge clk) disable iff (rst)
        (match_hit && stop_on_match) |=> (cnt == '0));

endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
    parameter int PULSE_W     = 16,
    parameter int PULSE_EXTRA = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               start,
    input  logic               arm_int,
    input  logic               arm_ext,
    input  logic               force_int,
    input  logic               force_ext,
    input  logic [PULSE_W-1:0] len,
    output logic               int_rst,
    output logic               ext_rst
);

    localparam int RW = PULSE_W + 1;

    logic [RW-1:0] remain;
    logic          sel_int, sel_ext;
    logic          active;

    assign active = (remain != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain  <= '0;
            sel_int <= 1'b0;
            sel_ext <= 1'b0;
        end else if (start) begin
            remain  <= RW'(len) + RW'(PULSE_EXTRA);
            sel_int <= arm_int;
            sel_ext <= arm_ext;
        end else if (active && tick) begin
            remain <= remain - 1'b1;
        end
    end

    assign int_rst = (active && sel_int) || force_int;
    assign ext_rst = (active && sel_ext) || force_ext;

    // R8: an armed start raises the selected output at the next edge
    a_r8_start_int: assert property (@(posedge clk) disable iff (rst)
        (start && arm_int) |=> int_rst);
    a_r8_start_ext: assert property (@(posedge clk) disable iff (rst)
        (start && arm_ext) |=> ext_rst);

    // R8: the pulse only shortens on ticks
    a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (active && !tick && !start) |=> $stable(remain));

endmodule

// File: rtl/wdog_match_timer.sv
module wdog_match_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PULSE_W     = 16,
    parameter int PULSE_EXTRA = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        por,
    input  logic        tick,
    input  logic        dbg_halt,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [4:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq,
    output logic        ext_match,
    output logic        int_rst,
    output logic        ext_rst
);

    logic             any_rst;
    reg_idx_e         idx;
    logic             ctrl_en, ctrl_dbg, clr_req;
    act_t             act;
    logic [CNT_W-1:0] match_val;
    em_mode_e         em_mode;
    logic             em_pin;
    logic [PULSE_W-1:0] plen;
    logic             irq_flag, cause_flag;
    logic             count_en, match_hit, pulse_start;
    logic [CNT_W-1:0] cnt;
    logic             wr_ctrl, wr_pin;

    assign any_rst  = rst || por;
    assign idx      = reg_idx_e'(addr[4:2]);
    assign wr_ctrl  = wr_en && (idx == RA_CTRL);
    assign wr_pin   = wr_en && (idx == RA_PIN);
    assign count_en = ctrl_en && tick && !(ctrl_dbg && dbg_halt) && !clr_req;
    assign pulse_start = match_hit && (act.int_rst_en || act.ext_rst_en);

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst           (any_rst),
        .count_en      (count_en),
        .clr_req       (clr_req),
        .stop_on_match (act.stop_on_match),
        .match_val     (match_val),
        .cnt           (cnt),
        .match_hit     (match_hit)
    );

    wdog_rst_pulse #(.PULSE_W(PULSE_W), .PULSE_EXTRA(PULSE_EXTRA)) u_pulse (
        .clk       (clk),
        .rst       (any_rst),
        .tick      (tick),
        .start     (pulse_start),
        .arm_int   (act.int_rst_en),
        .arm_ext   (act.ext_rst_en),
        .force_int (act.force_int),
        .force_ext (act.force_ext),
        .len       (plen),
        .int_rst   (int_rst),
        .ext_rst   (ext_rst)
    );

    always_ff @(posedge clk) begin
        if (any_rst) begin
            ctrl_en   <= 1'b0;
            ctrl_dbg  <= 1'b0;
            clr_req   <= 1'b0;
            act       <= '0;
            match_val <= '0;
            em_mode   <= EM_HOLD;
            em_pin    <= 1'b0;
            plen      <= '0;
            irq_flag  <= 1'b0;
        end else begin
            clr_req <= 1'b0;
            if (match_hit && act.stop_on_match) ctrl_en <= 1'b0;
            if (match_hit) em_pin <= em_next(em_mode, em_pin);

            if (match_hit)
                irq_flag <= 1'b1;
            else if (wr_en && idx == RA_IRQ && wdata[0])
                irq_flag <= 1'b0;

            if (wr_en) begin
                case (idx)
                    RA_CTRL: begin
                        ctrl_en  <= wdata[0];
                        clr_req  <= wdata[1];
                        ctrl_dbg <= wdata[2];
                    end
                    RA_ACT: act <= {wdata[6:2], wdata[0]};
                    RA_MATCH: match_val <= wdata[CNT_W-1:0];
                    RA_PIN: begin
                        em_mode <= em_mode_e'(wdata[5:4]);
                        em_pin  <= wdata[0];
                    end
                    RA_PLEN: plen <= wdata[PULSE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (por)              cause_flag <= 1'b0;
        else if (pulse_start) cause_flag <= 1'b1;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (idx)
                RA_IRQ:   rdata[0] = irq_flag;
                RA_CTRL:  rdata[2:0] = {ctrl_dbg, clr_req, ctrl_en};
                RA_CNT:   rdata = 32'(cnt);
                RA_ACT:   rdata[6:0] = {act[5:1], 1'b0, act.irq_en};
                RA_MATCH: rdata = 32'(match_val);
                RA_PIN:   rdata[5:0] = {em_mode, 3'b000, em_pin};
                RA_PLEN:  rdata = 32'(plen);
                RA_CAUSE: rdata[0] = cause_flag;
                default:  rdata = '0;
            endcase
        end
    end

    assign irq       = irq_flag && act.irq_en;
    assign ext_match = em_pin;

    // R5: a match always leaves the interrupt flag set
    a_r5_flag_set: assert property (@(posedge clk) disable iff (any_rst)
        match_hit |=> irq_flag);

    // R6: stop-on-match turns counting off unless software rewrites control
    a_r6_stop_en: assert property (@(posedge clk) disable iff (any_rst)
        (match_hit && act.stop_on_match && !wr_ctrl) |=> !ctrl_en);

    // R10: hold mode keeps the pin on a match
    a_r10_hold_pin: assert property (@(posedge clk) disable iff (any_rst)
        (match_hit && em_mode == EM_HOLD && !wr_pin) |=> $stable(em_pin));

    // R11: the cause flag survives the synchronous reset
    a_r11_cause_kept: assert property (@(posedge clk) disable iff (por)
        (rst && cause_flag) |=> cause_flag);

endmodule

// File: tb/wdog_match_timer_tb.sv
module wdog_match_timer_tb;
    import wdog_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b0, por = 1'b1, tick = 1'b0, dbg_halt = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, ext_match, int_rst, ext_rst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_match_timer u_dut (
        .clk(clk), .rst(rst), .por(por), .tick(tick), .dbg_halt(dbg_halt),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .ext_match(ext_match),
        .int_rst(int_rst), .ext_rst(ext_rst)
    );

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG_CYCLES) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, got %0d cycles expected < %0d", cycles, WATCHDOG_CYCLES);
            report();
        end
    end

    // monitor: pops expected read data as reads happen
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (rd_en) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read with no expected item, got %h expected entry", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pin(input logic got, input logic e, input string t);
        checks++;
        if (got !== e) begin
            errors++;
            $display("FAIL %s: got %b expected %b", t, got, e);
        end
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic sys_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
    endtask

    task automatic trig();
        wr(5'h04, 32'h1);
        ticks(1);
    endtask

    task automatic count_pulse(input int win, output int n_int, output int n_ext);
        n_int = 0; n_ext = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (int_rst) n_int++;
            if (ext_rst) n_ext++;
        end
    endtask

    initial begin
        int ni, ne;
        repeat (3) @(negedge clk);
        por = 1'b0;

        // R1 reset state
        rd(5'h04, 32'h0, "R1 ctrl");
        rd(5'h08, 32'h0, "R1 counter");
        rd(5'h1C, 32'h0, "R1 cause");
        rd(5'h14, 32'h0, "R1 pin mode");
        pin(irq, 1'b0, "R1 irq");
        pin(int_rst, 1'b0, "R1 int_rst");
        pin(ext_rst, 1'b0, "R1 ext_rst");
        pin(ext_match, 1'b0, "R1 ext_match");

        // R2 counting
        wr(5'h04, 32'h1);
        ticks(7);
        rd(5'h08, 32'd7, "R2 seven ticks");
        repeat (3) @(negedge clk);
        rd(5'h08, 32'd7, "R2 hold without tick");
        wr(5'h04, 32'h0);
        ticks(4);
        rd(5'h08, 32'd7, "R2 hold when disabled");

        // R3 debug freeze
        wr(5'h04, 32'h5);
        dbg_halt = 1'b1;
        ticks(4);
        rd(5'h08, 32'd7, "R3 frozen");
        dbg_halt = 1'b0;
        ticks(2);
        rd(5'h08, 32'd9, "R3 resumes");
        wr(5'h04, 32'h1);
        dbg_halt = 1'b1;
        ticks(1);
        dbg_halt = 1'b0;
        rd(5'h08, 32'd10, "R3 halt ignored without bit 2");

        // R4 clear request
        wr(5'h04, 32'h2);
        rd(5'h08, 32'd0, "R4 cleared");
        ticks(3);
        rd(5'h08, 32'd0, "R4 stays stopped");
        rd(5'h04, 32'd0, "R4 ctrl readback");

        // R5 / R7 match without stop
        sys_reset();
        wr(5'h10, 32'd5);
        wr(5'h0C, 32'h1);
        wr(5'h04, 32'h1);
        ticks(6);
        rd(5'h08, 32'd6, "R7 steps past match");
        rd(5'h00, 32'h1, "R5 flag set");
        pin(irq, 1'b1, "R5 irq pin");
        wr(5'h00, 32'h0);
        rd(5'h00, 32'h1, "R5 write 0 ignored");
        wr(5'h00, 32'h1);
        rd(5'h00, 32'h0, "R5 write 1 clears");
        pin(irq, 1'b0, "R5 irq pin cleared");

        // R6 stop on match
        sys_reset();
        wr(5'h10, 32'd5);
        wr(5'h0C, 32'h4);
        wr(5'h04, 32'h1);
        ticks(6);
        rd(5'h08, 32'd0, "R6 counter zero");
        rd(5'h04, 32'd0, "R6 enable cleared");
        ticks(3);
        rd(5'h08, 32'd0, "R6 stays stopped");
        rd(5'h00, 32'h1, "R6 flag set");
        pin(irq, 1'b0, "R5 irq masked when bit 0 clear");

        // R10 pin modes
        sys_reset();
        wr(5'h10, 32'd0);
        wr(5'h0C, 32'h4);
        wr(5'h14, 32'h31);
        pin(ext_match, 1'b1, "R10 pin loaded");
        trig();
        pin(ext_match, 1'b0, "R10 toggle low");
        trig();
        pin(ext_match, 1'b1, "R10 toggle high");
        wr(5'h14, 32'h20);
        trig();
        pin(ext_match, 1'b1, "R10 drive high");
        rd(5'h14, 32'h21, "R10 readback");
        wr(5'h14, 32'h11);
        trig();
        pin(ext_match, 1'b0, "R10 drive low");
        wr(5'h14, 32'h01);
        trig();
        pin(ext_match, 1'b1, "R10 hold");

        // R9 forced outputs
        sys_reset();
        wr(5'h0C, 32'h20);
        pin(int_rst, 1'b1, "R9 force int");
        pin(ext_rst, 1'b0, "R9 ext idle");
        wr(5'h0C, 32'h40);
        pin(ext_rst, 1'b1, "R9 force ext");
        pin(int_rst, 1'b0, "R9 int idle");
        wr(5'h0C, 32'h0);
        pin(ext_rst, 1'b0, "R9 release");
        rd(5'h1C, 32'h0, "R11 force does not set cause");

        // R8 pulse width, internal
        sys_reset();
        wr(5'h18, 32'd3);
        wr(5'h10, 32'd2);
        wr(5'h0C, 32'h0C);
        @(negedge clk); tick = 1'b1;
        wr(5'h04, 32'h1);
        count_pulse(30, ni, ne);
        tick = 1'b0;
        pin(ni == 9, 1'b1, "R8 int width len+6");
        if (ni != 9) $display("  R8 int width got %0d expected 9", ni);
        pin(ne == 0, 1'b1, "R8 ext stays low");

        // R8 pulse width, external, zero length
        sys_reset();
        wr(5'h18, 32'd0);
        wr(5'h10, 32'd2);
        wr(5'h0C, 32'h14);
        @(negedge clk); tick = 1'b1;
        wr(5'h04, 32'h1);
        count_pulse(30, ni, ne);
        tick = 1'b0;
        pin(ne == 6, 1'b1, "R8 ext width len+6");
        if (ne != 6) $display("  R8 ext width got %0d expected 6", ne);
        pin(ni == 0, 1'b1, "R8 int stays low");

        // R11 cause flag
        rd(5'h1C, 32'h1, "R11 cause set");
        wr(5'h1C, 32'h0);
        rd(5'h1C, 32'h1, "R11 write ignored");
        sys_reset();
        rd(5'h1C, 32'h1, "R11 kept through rst");
        @(negedge clk); por = 1'b1;
        @(negedge clk); por = 1'b0;
        rd(5'h1C, 32'h0, "R11 cleared by por");

        // R12 long timeout and maximum pulse length
        wr(5'h10, timeout_ticks(MAX_TIMEOUT_S)[31:0]);
        rd(5'h10, 32'd780_000_000, "R12 60 s match");
        wr(5'h18, 32'hFFFF);
        rd(5'h18, 32'h0000_FFFF, "R12 pulse length");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        report();
    end

endmodule